// File: doc/BRIEF.md
# DS1 Frame and Superframe Timing Generator

This block keeps the bit, frame and superframe position of a 1.544 Mbit/s DS1 stream on both the transmit and the receive side of a T1 framer. It runs on a fast system clock and advances only on cycles where a bit-rate enable is high. Each frame is 193 bit periods: the framing bit at position 0, then 24 channels of 8 bits at positions 1 to 192. Frames are grouped into superframes of 12 frames in D4 mode or 24 frames in ESF mode.

On the transmit side the superframe counter runs freely. A low-going pulse on an active-low sync input makes the next transmit frame frame 1. On the receive side the framer's alignment logic can restart the superframe the same way. The block reports a superframe-start pulse only while alignment is reported, and it is not involved in finding that alignment. In loopback the receive counter is driven from the transmit bit enable. In ESF mode the block also produces a 4 kHz data link clock and a per-bit strobe for the framing bits that carry the data link.

Top module: `ds1_frame_timer`

## Requirements
- R1: While reset is asserted, both sides sit at bit position 0 and frame 1. Both data link clocks are 0, and with the bit enables low every marker and pulse output is 0.
- R2: On each cycle with the side's bit enable high, the bit position advances by one and wraps from 192 to 0. Without the enable the position and frame number hold.
- R3: The frame marker of a side is high exactly on enable cycles at bit position 0, so consecutive markers are 193 enables apart.
- R4: At a frame boundary, meaning an enable at bit position 192, the frame number advances by one. It returns to 1 once it is at or above the superframe length, which is 12 when esf_mode is 0 and 24 when it is 1. This also covers a frame number left above 12 by a switch to D4 mode.
- R5: A falling edge on tx_sf_n is taken through a two-stage synchronizer and detected as high-then-low between the last two synchronized samples. It makes the next transmit frame boundary load frame 1. While tx_sf_n stays high the transmit count free-runs.
- R6: tx_sf_mark is the transmit frame marker qualified by frame number 1.
- R7: The receive counter advances on rx_bit_en, or on tx_bit_en while loopback is 1. rx_frame_mark is its 8 kHz frame marker.
- R8: A high rx_sf_align pulse makes the next receive frame boundary load frame 1.
- R9: rx_sf_pulse is high on the receive enable cycle at bit 192 when the next frame will be frame 1, but only while rx_in_sync is 1.
- R10: Each data link clock is registered. It is 1 one cycle after its side is in ESF mode in an odd-numbered frame, and 0 otherwise, so its rising edge starts each odd frame.
- R11: Each data link strobe is the side's frame marker in an odd-numbered frame in ESF mode. It is always 0 in D4 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| esf_mode | input | 1 | 1 selects 24-frame ESF superframe, 0 selects 12-frame D4 |
| loopback | input | 1 | 1 drives the receive counter from tx_bit_en |
| tx_bit_en | input | 1 | Transmit bit-rate enable |
| tx_sf_n | input | 1 | Active-low transmit superframe sync, asynchronous |
| rx_bit_en | input | 1 | Receive (extracted) bit-rate enable |
| rx_sf_align | input | 1 | Receive superframe restart request from the alignment logic |
| rx_in_sync | input | 1 | Receive alignment status |
| tx_bit_pos | output | 8 | Transmit bit position 0..192 |
| tx_frame_num | output | 5 | Transmit frame number 1..24 |
| tx_frame_mark | output | 1 | Transmit 8 kHz frame marker |
| tx_sf_mark | output | 1 | Transmit superframe start marker |
| tx_fdl_clk | output | 1 | Transmit 4 kHz data link clock |
| tx_fdl_strobe | output | 1 | Transmit data link bit strobe |
| rx_bit_pos | output | 8 | Receive bit position 0..192 |
| rx_frame_num | output | 5 | Receive frame number 1..24 |
| rx_frame_mark | output | 1 | Receive 8 kHz frame marker |
| rx_sf_pulse | output | 1 | Receive "next frame is frame 1" pulse, gated by rx_in_sync |
| rx_fdl_clk | output | 1 | Receive 4 kHz data link clock |
| rx_fdl_strobe | output | 1 | Receive data link bit strobe |

## Verification
The bench drives a sync pulse in the middle of a D4 superframe. A design that ignored it, or applied it at once instead of at the frame boundary, would show a frame number other than 1 after the next marker, or a jump in the middle of a frame. Switching from ESF to D4 while the count is at frame 18 targets a wrap written as an equality, which would run past 24 and leave the frame range. Receive sync is toggled at random during superframe ends, together with random alignment requests and a loopback section. A pulse that ignored sync status, ignored a pending restart, or kept following rx_bit_en in loopback would disagree with the bench's cycle model. The bench also measures the marker spacing at exactly 193 enables, which an off-by-one bit wrap would break.

// File: rtl/ds1_timing_pkg.sv
package ds1_timing_pkg;

  localparam int DS1_FRAME_BITS = 193;
  localparam int DS1_D4_FRAMES  = 12;
  localparam int DS1_ESF_FRAMES = 24;
  localparam int DS1_SYNC_STAGES = 2;

  typedef enum logic {
    SF_MODE_D4  = 1'b0,
    SF_MODE_ESF = 1'b1
  } sf_mode_e;

endpackage

// File: rtl/ds1_rst_sync.sv
module ds1_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ds1_sync_in.sv
module ds1_sync_in #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ds1_pos_ctr.sv
module ds1_pos_ctr #(
  parameter int FRAME_BITS = 193,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int BIT_W      = 8,
  parameter int FRM_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             esf_mode,
  input  logic             restart_req,
  output logic [BIT_W-1:0] bit_pos,
  output logic [FRM_W-1:0] frame_num,
  output logic             frame_mark,
  output logic             sf_end
);

  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS - 1);
  localparam logic [FRM_W-1:0] D4_LEN    = FRM_W'(D4_FRAMES);
  localparam logic [FRM_W-1:0] ESF_LEN   = FRM_W'(ESF_FRAMES);
  localparam logic [FRM_W-1:0] FIRST_FRM = FRM_W'(1);

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [FRM_W-1:0] frame_q, frame_d;
  logic             pend_q, pend_d;
  logic [FRM_W-1:0] sf_len;
  logic             at_end;
  logic             restart;
  logic             wrap;

  always_comb begin
    sf_len  = esf_mode ? ESF_LEN : D4_LEN;
    at_end  = (bit_q == LAST_BIT);
    restart = pend_q | restart_req;
    wrap    = restart | (frame_q >= sf_len);
  end

  // next-state
  always_comb begin
    bit_d   = bit_q;
    frame_d = frame_q;
    pend_d  = restart;
    if (bit_en) begin
      if (at_end) begin
        bit_d   = '0;
        frame_d = wrap ? FIRST_FRM : frame_q + FIRST_FRM;
        pend_d  = 1'b0;
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      frame_q <= FIRST_FRM;
      pend_q  <= 1'b0;
    end else begin
      bit_q   <= bit_d;
      frame_q <= frame_d;
      pend_q  <= pend_d;
    end
  end

  assign bit_pos    = bit_q;
  assign frame_num  = frame_q;
  assign frame_mark = bit_en & (bit_q == '0);
  assign sf_end     = bit_en & at_end & wrap;

endmodule

// File: rtl/ds1_fdl_gen.sv
module ds1_fdl_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic esf_mode,
  input  logic frame_odd,
  input  logic frame_mark,
  output logic fdl_clk,
  output logic fdl_strobe
);

  logic clk_q, clk_d;

  always_comb begin
    clk_d = esf_mode & frame_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= clk_d;
  end

  assign fdl_clk    = clk_q;
  assign fdl_strobe = esf_mode & frame_odd & frame_mark;

endmodule

// File: rtl/ds1_frame_timer.sv
module ds1_frame_timer
  import ds1_timing_pkg::*;
#(
  parameter int FRAME_BITS  = DS1_FRAME_BITS,
  parameter int D4_FRAMES   = DS1_D4_FRAMES,
  parameter int ESF_FRAMES  = DS1_ESF_FRAMES,
  parameter int SYNC_STAGES = DS1_SYNC_STAGES,
  localparam int BIT_W = $clog2(FRAME_BITS),
  localparam int FRM_W = $clog2(ESF_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             esf_mode,
  input  logic             loopback,
  input  logic             tx_bit_en,
  input  logic             tx_sf_n,
  input  logic             rx_bit_en,
  input  logic             rx_sf_align,
  input  logic             rx_in_sync,
  output logic [BIT_W-1:0] tx_bit_pos,
  output logic [FRM_W-1:0] tx_frame_num,
  output logic             tx_frame_mark,
  output logic             tx_sf_mark,
  output logic             tx_fdl_clk,
  output logic             tx_fdl_strobe,
  output logic [BIT_W-1:0] rx_bit_pos,
  output logic [FRM_W-1:0] rx_frame_num,
  output logic             rx_frame_mark,
  output logic             rx_sf_pulse,
  output logic             rx_fdl_clk,
  output logic             rx_fdl_strobe
);

  localparam int SIDES = 2;
  localparam int TX = 0;
  localparam int RX = 1;

  logic rst_sync_n;
  logic sf_sync;
  logic sf_prev_q, sf_prev_d;
  logic sf_fell;
  logic rx_en;
  logic tx_sf_end_unused;

  logic             side_en      [SIDES];
  logic             side_restart [SIDES];
  logic [BIT_W-1:0] side_bit     [SIDES];
  logic [FRM_W-1:0] side_frm     [SIDES];
  logic             side_mark    [SIDES];
  logic             side_sf_end  [SIDES];
  logic             side_fclk    [SIDES];
  logic             side_fstb    [SIDES];

  ds1_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ds1_sync_in #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sf_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (tx_sf_n),
    .q     (sf_sync)
  );

  // falling-edge detect on the synchronized sync input
  always_comb begin
    sf_prev_d = sf_sync;
    sf_fell   = sf_prev_q & ~sf_sync;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sf_prev_q <= 1'b1;
    else             sf_prev_q <= sf_prev_d;
  end

  always_comb begin
    rx_en            = loopback ? tx_bit_en : rx_bit_en;
    side_en[TX]      = tx_bit_en;
    side_en[RX]      = rx_en;
    side_restart[TX] = sf_fell;
    side_restart[RX] = rx_sf_align;
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    ds1_pos_ctr #(
      .FRAME_BITS (FRAME_BITS),
      .D4_FRAMES  (D4_FRAMES),
      .ESF_FRAMES (ESF_FRAMES),
      .BIT_W      (BIT_W),
      .FRM_W      (FRM_W)
    ) u_ctr (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .bit_en      (side_en[s]),
      .esf_mode    (esf_mode),
      .restart_req (side_restart[s]),
      .bit_pos     (side_bit[s]),
      .frame_num   (side_frm[s]),
      .frame_mark  (side_mark[s]),
      .sf_end      (side_sf_end[s])
    );

    ds1_fdl_gen u_fdl (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .esf_mode   (esf_mode),
      .frame_odd  (side_frm[s][0]),
      .frame_mark (side_mark[s]),
      .fdl_clk    (side_fclk[s]),
      .fdl_strobe (side_fstb[s])
    );
  end

  assign tx_bit_pos       = side_bit[TX];
  assign tx_frame_num     = side_frm[TX];
  assign tx_frame_mark    = side_mark[TX];
  assign tx_sf_mark       = side_mark[TX] & (side_frm[TX] == FRM_W'(1));
  assign tx_fdl_clk       = side_fclk[TX];
  assign tx_fdl_strobe    = side_fstb[TX];
  assign tx_sf_end_unused = side_sf_end[TX];

  assign rx_bit_pos    = side_bit[RX];
  assign rx_frame_num  = side_frm[RX];
  assign rx_frame_mark = side_mark[RX];
  assign rx_sf_pulse   = side_sf_end[RX] & rx_in_sync;
  assign rx_fdl_clk    = side_fclk[RX];
  assign rx_fdl_strobe = side_fstb[RX];

endmodule

// File: rtl/ds1_frame_timer_chk.sv
module ds1_frame_timer_chk #(
  parameter int FRAME_BITS = 193,
  parameter int D4_FRAMES  = 12,
  parameter int ESF_FRAMES = 24,
  parameter int BIT_W      = 8,
  parameter int FRM_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             esf_mode,
  input logic             tx_bit_en,
  input logic             rx_in_sync,
  input logic [BIT_W-1:0] tx_bit_pos,
  input logic [FRM_W-1:0] tx_frame_num,
  input logic             tx_fdl_clk,
  input logic             tx_fdl_strobe,
  input logic [BIT_W-1:0] rx_bit_pos,
  input logic [FRM_W-1:0] rx_frame_num,
  input logic             rx_sf_pulse
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  logic [FRM_W-1:0] cur_len;
  assign cur_len = esf_mode ? FRM_W'(ESF_FRAMES) : FRM_W'(D4_FRAMES);

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_pos <= LAST_BIT); // R2

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit_en |=> $stable(tx_bit_pos) && $stable(tx_frame_num)); // R2

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_en && tx_bit_pos != LAST_BIT) |=> tx_bit_pos == $past(tx_bit_pos) + BIT_W'(1)); // R2

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_num >= FRM_W'(1) && tx_frame_num <= FRM_W'(ESF_FRAMES)); // R4

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_en && tx_bit_pos == LAST_BIT && tx_frame_num >= cur_len)
      |=> tx_frame_num == FRM_W'(1) && tx_bit_pos == '0); // R4

  AST_RX_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sf_pulse |-> rx_in_sync); // R9

  AST_RX_PULSE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sf_pulse |=> rx_frame_num == FRM_W'(1) && rx_bit_pos == '0); // R9

  AST_FDL_CLK_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (esf_mode && tx_frame_num[0]) |=> tx_fdl_clk); // R10

  AST_FDL_QUIET_D4: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_mode |-> !tx_fdl_strobe); // R11

endmodule

bind ds1_frame_timer ds1_frame_timer_chk #(
  .FRAME_BITS (FRAME_BITS),
  .D4_FRAMES  (D4_FRAMES),
  .ESF_FRAMES (ESF_FRAMES),
  .BIT_W      (BIT_W),
  .FRM_W      (FRM_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .esf_mode      (esf_mode),
  .tx_bit_en     (tx_bit_en),
  .rx_in_sync    (rx_in_sync),
  .tx_bit_pos    (tx_bit_pos),
  .tx_frame_num  (tx_frame_num),
  .tx_fdl_clk    (tx_fdl_clk),
  .tx_fdl_strobe (tx_fdl_strobe),
  .rx_bit_pos    (rx_bit_pos),
  .rx_frame_num  (rx_frame_num),
  .rx_sf_pulse   (rx_sf_pulse)
);

// File: tb/ds1_frame_timer_tb.sv
`timescale 1ns/1ps
module ds1_frame_timer_tb;

  localparam int LAST = 192;

  logic clk = 1'b0;
  logic rst_n;
  logic esf_mode, loopback, tx_bit_en, tx_sf_n, rx_bit_en, rx_sf_align, rx_in_sync;
  logic [7:0] tx_bit_pos, rx_bit_pos;
  logic [4:0] tx_frame_num, rx_frame_num;
  logic tx_frame_mark, tx_sf_mark, tx_fdl_clk, tx_fdl_strobe;
  logic rx_frame_mark, rx_sf_pulse, rx_fdl_clk, rx_fdl_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model state
  int m_tbit, m_tfr, m_rbit, m_rfr;
  bit m_tpend, m_rpend, m_s1, m_s2, m_prev, m_tclk, m_rclk;
  int en_since;
  bit have_mark;

  always #10 clk = ~clk;

  ds1_frame_timer u_dut (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .loopback(loopback),
    .tx_bit_en(tx_bit_en), .tx_sf_n(tx_sf_n), .rx_bit_en(rx_bit_en),
    .rx_sf_align(rx_sf_align), .rx_in_sync(rx_in_sync),
    .tx_bit_pos(tx_bit_pos), .tx_frame_num(tx_frame_num),
    .tx_frame_mark(tx_frame_mark), .tx_sf_mark(tx_sf_mark),
    .tx_fdl_clk(tx_fdl_clk), .tx_fdl_strobe(tx_fdl_strobe),
    .rx_bit_pos(rx_bit_pos), .rx_frame_num(rx_frame_num),
    .rx_frame_mark(rx_frame_mark), .rx_sf_pulse(rx_sf_pulse),
    .rx_fdl_clk(rx_fdl_clk), .rx_fdl_strobe(rx_fdl_strobe)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  function automatic int sf_len(bit esf);
    return esf ? 24 : 12;
  endfunction

  function automatic int next_frame(int fr, bit restart, bit esf);
    if (restart || fr >= sf_len(esf)) return 1;
    return fr + 1;
  endfunction

  task automatic model_reset();
    m_tbit = 0; m_tfr = 1; m_rbit = 0; m_rfr = 1;
    m_tpend = 0; m_rpend = 0; m_s1 = 1; m_s2 = 1; m_prev = 1;
    m_tclk = 0; m_rclk = 0; en_since = 0; have_mark = 0;
  endtask

  // called just after a falling edge with inputs settled
  task automatic step();
    bit et, er, fell, rs_t, rs_r, t_mark, r_mark;
    #1;
    et = tx_bit_en;
    er = loopback ? tx_bit_en : rx_bit_en;
    fell = m_prev & ~m_s2;
    rs_t = m_tpend | fell;
    rs_r = m_rpend | rx_sf_align;
    t_mark = et && m_tbit == 0;
    r_mark = er && m_rbit == 0;

    chk("R2", "tx_bit_pos", tx_bit_pos, m_tbit);
    chk("R4 R5", "tx_frame_num", tx_frame_num, m_tfr);
    chk("R3", "tx_frame_mark", tx_frame_mark, t_mark);
    chk("R6", "tx_sf_mark", tx_sf_mark, t_mark && m_tfr == 1);
    chk("R10", "tx_fdl_clk", tx_fdl_clk, m_tclk);
    chk("R11", "tx_fdl_strobe", tx_fdl_strobe, esf_mode && t_mark && m_tfr % 2 == 1);
    chk("R7", "rx_bit_pos", rx_bit_pos, m_rbit);
    chk("R7 R8", "rx_frame_num", rx_frame_num, m_rfr);
    chk("R7", "rx_frame_mark", rx_frame_mark, r_mark);
    chk("R9", "rx_sf_pulse", rx_sf_pulse,
        er && m_rbit == LAST && (rs_r || m_rfr >= sf_len(esf_mode)) && rx_in_sync);
    chk("R10", "rx_fdl_clk", rx_fdl_clk, m_rclk);
    chk("R11", "rx_fdl_strobe", rx_fdl_strobe, esf_mode && r_mark && m_rfr % 2 == 1);

    if (tx_frame_mark) begin
      if (have_mark) chk("R3", "enables between markers", en_since, 193);
      en_since = 0;
      have_mark = 1;
    end
    if (et) en_since++;

    // advance model across the coming rising edge
    m_tclk = esf_mode && (m_tfr % 2 == 1);
    m_rclk = esf_mode && (m_rfr % 2 == 1);
    if (et) begin
      if (m_tbit == LAST) begin
        m_tbit = 0; m_tfr = next_frame(m_tfr, rs_t, esf_mode); m_tpend = 0;
      end else begin
        m_tbit++; m_tpend = rs_t;
      end
    end else m_tpend = rs_t;
    if (er) begin
      if (m_rbit == LAST) begin
        m_rbit = 0; m_rfr = next_frame(m_rfr, rs_r, esf_mode); m_rpend = 0;
      end else begin
        m_rbit++; m_rpend = rs_r;
      end
    end else m_rpend = rs_r;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = tx_sf_n;
    @(negedge clk);
  endtask

  // random traffic: enables with probability 3/4, optional random events
  task automatic run(int cycles, int sf_rate, int align_rate, bit rand_sync);
    for (int i = 0; i < cycles; i++) begin
      tx_bit_en   = ($urandom % 4) != 0;
      rx_bit_en   = ($urandom % 4) != 0;
      tx_sf_n     = (sf_rate != 0) ? (($urandom % sf_rate) != 0) : 1'b1;
      rx_sf_align = (align_rate != 0) ? (($urandom % align_rate) == 0) : 1'b0;
      if (rand_sync && ($urandom % 500) == 0) rx_in_sync = ~rx_in_sync;
      step();
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; esf_mode = 0; loopback = 0; tx_bit_en = 0; rx_bit_en = 0;
    tx_sf_n = 1; rx_sf_align = 0; rx_in_sync = 1;
    model_reset();
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "tx_bit_pos", tx_bit_pos, 0);
    chk("R1", "tx_frame_num", tx_frame_num, 1);
    chk("R1", "rx_frame_num", rx_frame_num, 1);
    chk("R1", "tx_fdl_clk", tx_fdl_clk, 0);
    chk("R1", "rx_sf_pulse", rx_sf_pulse, 0);
    chk("R1", "tx_frame_mark", tx_frame_mark, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) step();

    // D4 free run across several superframe wraps (R2 R3 R4 R6)
    run(8000, 0, 0, 0);

    // directed R5: sync pulse in the middle of a D4 superframe
    tx_bit_en = 1; rx_bit_en = 1;
    while (!(m_tfr == 5 && m_tbit == 100)) step();
    tx_sf_n = 0; step(); step(); tx_sf_n = 1;
    while (!tx_frame_mark) step();
    #1;
    chk("R5", "frame after mid-superframe sync", tx_frame_num, 1);
    run(4000, 0, 0, 0);

    // ESF with data link, random sync pulses (R4 R5 R10 R11)
    esf_mode = 1;
    run(20000, 3000, 0, 0);

    // directed R4: ESF -> D4 switch at frame 18
    tx_bit_en = 1;
    while (!(m_tfr == 18 && m_tbit == 50)) step();
    esf_mode = 0;
    while (!tx_frame_mark) step();
    #1;
    chk("R4", "frame after switch to D4 above length", tx_frame_num, 1);
    run(3000, 0, 0, 0);

    // receive side: random sync status and alignment (R8 R9)
    esf_mode = 1;
    run(20000, 0, 6000, 1);
    rx_in_sync = 0;
    run(8000, 0, 0, 0);

    // loopback (R7)
    loopback = 1; rx_in_sync = 1;
    run(12000, 0, 5000, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule